// File: doc/BRIEF.md
# Pack-Family Bit-Manipulation Execution Unit

This unit recognises and executes the register-register pack operations of a bit-manipulation instruction set extension. It splits two source operands into halves or bytes and joins the selected pieces into one destination value. The machine word width is a parameter (32 or 64). At width 64 there are also two 32-bit word forms, whose result is sign-extended from bit 31.

The unit receives a raw 32-bit instruction word, both source values and an enable bit for the extension. It returns a result, a flag that says the encoding belongs to this unit, and a flag that says the encoding may not execute. Any encoding the unit does not own gives a zero result and two low flags. The unit can therefore sit beside other execution units, and their results can be ORed together. A parameter adds an output register stage with a synchronous active-high reset.

Top module: `bmu_pack_unit`

## Requirements
- R1: An instruction is owned when bits [31:25], [14:12] and [6:0] match one of five encodings. The register fields [24:15] and [11:7] are ignored. The five encodings are: pack (0000100, 100, 0110011), packu (0100100, 100, 0110011), packh (0000100, 111, 0110011), packw (0000100, 100, 0111011) and packuw (0100100, 100, 0111011). For an owned instruction `known_o` is 1.
- R2: pack returns the low half of rs1 in the low half of the result and the low half of rs2 in the high half. A half is XLEN/2 bits.
- R3: packu returns the high half of rs1 in the low half of the result and the high half of rs2 in the high half.
- R4: packh returns rs1[7:0] in bits 7:0 and rs2[7:0] in bits 15:8. Every bit above bit 15 is zero.
- R5: packw (XLEN 64) forms the 32-bit value {rs2[15:0], rs1[15:0]} and sign-extends it from bit 31.
- R6: packuw (XLEN 64) forms the 32-bit value {rs2[31:16], rs1[31:16]} and sign-extends it from bit 31. Operand bits 63:32 have no effect.
- R7: When `bext_en_i` is 0, an owned encoding gives `illegal_o`=1, `known_o`=1 and a result of zero.
- R8: When XLEN is 32, packw and packuw give `illegal_o`=1, `known_o`=1 and a result of zero, even with the extension enabled.
- R9: Any encoding that is not owned gives `known_o`=0, `illegal_o`=0 and a result of zero.
- R10: When OUT_REG is 1, the outputs show the inputs one clock edge later. While `rst` is high, a clock edge sets all outputs to zero.
- R11: `illegal_o` is never 1 while `known_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | First source operand |
| rs2_val_i | input | XLEN | Second source operand |
| bext_en_i | input | 1 | Bit-manipulation extension enabled |
| rd_val_o | output | XLEN | Result, zero unless legal and owned |
| known_o | output | 1 | Encoding belongs to this unit |
| illegal_o | output | 1 | Owned encoding that may not execute |

## Verification
The bench drives a 64-bit and a 32-bit instance side by side. This catches a half size that was fixed to one width: at 32 bits such a design would move 32-bit halves and corrupt the result.

Word forms are driven with bit 15 or bit 31 of the packed value set and clear, and with differing operand bits 63:32. This exposes a missing or zero sign extension, and a packuw that takes its halves from the full register. Packh is driven with all-ones operands to catch leakage above bit 15.

The remaining stimulus targets decode. Near-miss encodings (one funct7 bit off, the wrong funct3, the word opcode with the packh funct3) catch loose matching. Disabled-extension cases catch a result that leaks while the illegal flag is raised.

// File: rtl/bmu_pack_pkg.sv
package bmu_pack_pkg;

  // Field values the decoder compares against (positions fixed by the ISA)
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REG32 = 7'b0111011;
  localparam logic [6:0] F7_LOW    = 7'b0000100;
  localparam logic [6:0] F7_UPP    = 7'b0100100;
  localparam logic [2:0] F3_HALF   = 3'b100;
  localparam logic [2:0] F3_BYTE   = 3'b111;

  typedef enum logic [2:0] {
    PK_NONE   = 3'd0,
    PK_HALF   = 3'd1,
    PK_HALFU  = 3'd2,
    PK_BYTE   = 3'd3,
    PK_WORD   = 3'd4,
    PK_WORDU  = 3'd5
  } pk_op_e;

endpackage

// File: rtl/bmu_pack_decode.sv
module bmu_pack_decode
  import bmu_pack_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [6:0] funct7_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] opcode_i,
  input  logic       ext_on_i,
  output pk_op_e     op_o,
  output logic       hit_o,
  output logic       bad_o
);

  localparam bit WORD_FORMS = (XLEN == 64);

  logic is_reg, is_reg32;
  logic m_half, m_halfu, m_byte, m_word, m_wordu;
  logic word_sel, refuse;
  pk_op_e op_raw;

  assign is_reg   = (opcode_i == OPC_REG);
  assign is_reg32 = (opcode_i == OPC_REG32);

  assign m_half  = is_reg   && funct7_i == F7_LOW && funct3_i == F3_HALF;
  assign m_halfu = is_reg   && funct7_i == F7_UPP && funct3_i == F3_HALF;
  assign m_byte  = is_reg   && funct7_i == F7_LOW && funct3_i == F3_BYTE;
  assign m_word  = is_reg32 && funct7_i == F7_LOW && funct3_i == F3_HALF;
  assign m_wordu = is_reg32 && funct7_i == F7_UPP && funct3_i == F3_HALF;

  assign word_sel = m_word | m_wordu;

  always_comb begin
    op_raw = PK_NONE;
    if (m_half)  op_raw = PK_HALF;
    if (m_halfu) op_raw = PK_HALFU;
    if (m_byte)  op_raw = PK_BYTE;
    if (m_word)  op_raw = PK_WORD;
    if (m_wordu) op_raw = PK_WORDU;
  end

  assign hit_o  = m_half | m_halfu | m_byte | word_sel;
  assign refuse = !ext_on_i || (word_sel && !WORD_FORMS);
  assign bad_o  = hit_o && refuse;
  // A refused operation is turned into no operation, which zeroes the datapath
  assign op_o   = bad_o ? PK_NONE : op_raw;

endmodule

// File: rtl/bmu_pack_datapath.sv
module bmu_pack_datapath
  import bmu_pack_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pk_op_e          op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  localparam int HALF  = XLEN / 2;
  localparam int WBITS = 32;
  localparam int WHALF = WBITS / 2;

  logic [XLEN-1:0]  r_half, r_halfu, r_byte, r_word, r_wordu;
  logic [WBITS-1:0] w_lo, w_hi;

  assign r_half  = {b_i[HALF-1:0], a_i[HALF-1:0]};
  assign r_halfu = {b_i[XLEN-1:HALF], a_i[XLEN-1:HALF]};
  assign r_byte  = {{(XLEN-16){1'b0}}, b_i[7:0], a_i[7:0]};

  assign w_lo = {b_i[WHALF-1:0], a_i[WHALF-1:0]};
  assign w_hi = {b_i[WBITS-1:WHALF], a_i[WBITS-1:WHALF]};

  generate
    if (XLEN > WBITS) begin : g_sext
      assign r_word  = {{(XLEN-WBITS){w_lo[WBITS-1]}}, w_lo};
      assign r_wordu = {{(XLEN-WBITS){w_hi[WBITS-1]}}, w_hi};
    end else begin : g_narrow
      assign r_word  = w_lo;
      assign r_wordu = w_hi;
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      PK_HALF:  res_o = r_half;
      PK_HALFU: res_o = r_halfu;
      PK_BYTE:  res_o = r_byte;
      PK_WORD:  res_o = r_word;
      PK_WORDU: res_o = r_wordu;
      default:  res_o = '0;
    endcase
  end

  // Guards on the datapath output, checked against the selected operation
  always_comb begin
    if (op_i == PK_BYTE) begin
      assert_byte_upper_zero_R4: assert (res_o[XLEN-1:16] == '0)
        else $error("byte pack leaked above bit 15");
    end
    if (op_i == PK_HALF) begin
      assert_half_low_src_R2: assert (res_o[HALF-1:0] == a_i[HALF-1:0])
        else $error("half pack low half wrong");
    end
  end

  generate
    if (XLEN > WBITS) begin : g_word_chk
      always_comb begin
        if (op_i == PK_WORD || op_i == PK_WORDU) begin
          assert_word_sext_R5: assert (res_o[XLEN-1:WBITS] == {(XLEN-WBITS){res_o[WBITS-1]}})
            else $error("word result not sign-extended");
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bmu_pack_outstage.sv
module bmu_pack_outstage #(
  parameter int  XLEN    = 64,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] res_i,
  input  logic            hit_i,
  input  logic            bad_i,
  output logic [XLEN-1:0] res_o,
  output logic            hit_o,
  output logic            bad_o
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_o <= '0;
          hit_o <= 1'b0;
          bad_o <= 1'b0;
        end else begin
          res_o <= res_i;
          hit_o <= hit_i;
          bad_o <= bad_i;
        end
      end
    end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign res_o = res_i;
      assign hit_o = hit_i;
      assign bad_o = bad_i;
    end
  endgenerate

endmodule

// File: rtl/bmu_pack_unit.sv
module bmu_pack_unit
  import bmu_pack_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic            bext_en_i,
  output logic [XLEN-1:0] rd_val_o,
  output logic            known_o,
  output logic            illegal_o
);

  pk_op_e          op_sel;
  logic            hit_c, bad_c;
  logic [XLEN-1:0] res_c;

  // Register specifier fields play no part in this unit
  logic unused_regfields;
  assign unused_regfields = ^{insn_i[24:15], insn_i[11:7]};

  bmu_pack_decode #(.XLEN(XLEN)) u_dec (
    .funct7_i (insn_i[31:25]),
    .funct3_i (insn_i[14:12]),
    .opcode_i (insn_i[6:0]),
    .ext_on_i (bext_en_i),
    .op_o     (op_sel),
    .hit_o    (hit_c),
    .bad_o    (bad_c)
  );

  bmu_pack_datapath #(.XLEN(XLEN)) u_dp (
    .op_i  (op_sel),
    .a_i   (rs1_val_i),
    .b_i   (rs2_val_i),
    .res_o (res_c)
  );

  bmu_pack_outstage #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst   (rst),
    .res_i (res_c),
    .hit_i (hit_c),
    .bad_i (bad_c),
    .res_o (rd_val_o),
    .hit_o (known_o),
    .bad_o (illegal_o)
  );

  assert_bad_needs_hit_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> known_o);

  assert_refused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (rd_val_o == '0));

  assert_foreign_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !known_o |-> (rd_val_o == '0 && !illegal_o));

  generate
    if (OUT_REG) begin : g_reg_chk
      assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (rd_val_o == '0 && !known_o && !illegal_o));

      assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_val_o == $past(res_c) && known_o == $past(hit_c)
                  && illegal_o == $past(bad_c)));
    end
  endgenerate

endmodule

// File: tb/sim_bmu_pack_unit.sv
module sim_bmu_pack_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'h0;
  logic [63:0] a = '0, b = '0;
  logic        en = 1'b1;

  logic [63:0] r64;
  logic        k64, x64;
  logic [31:0] r32;
  logic        k32, x32;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bmu_pack_unit #(.XLEN(64), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .insn_i(insn), .rs1_val_i(a), .rs2_val_i(b),
    .bext_en_i(en), .rd_val_o(r64), .known_o(k64), .illegal_o(x64)
  );

  bmu_pack_unit #(.XLEN(32), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst(rst), .insn_i(insn), .rs1_val_i(a[31:0]), .rs2_val_i(b[31:0]),
    .bext_en_i(en), .rd_val_o(r32), .known_o(k32), .illegal_o(x32)
  );

  // kinds: 0 foreign, 1 pack, 2 packu, 3 packh, 4 packw, 5 packuw
  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [6:0] opc, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  function automatic logic [63:0] ref64(input int k, input logic [63:0] x, input logic [63:0] y);
    logic [31:0] w;
    case (k)
      1: return {y[31:0], x[31:0]};
      2: return {y[63:32], x[63:32]};
      3: return {48'h0, y[7:0], x[7:0]};
      4: begin w = {y[15:0], x[15:0]};  return {{32{w[31]}}, w}; end
      5: begin w = {y[31:16], x[31:16]}; return {{32{w[31]}}, w}; end
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [31:0] ref32(input int k, input logic [31:0] x, input logic [31:0] y);
    case (k)
      1: return {y[15:0], x[15:0]};
      2: return {y[31:16], x[31:16]};
      3: return {16'h0, y[7:0], x[7:0]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [63:0] x, input logic [63:0] y,
                       input logic e);
    @(negedge clk);
    insn = i; a = x; b = y; en = e;
    @(negedge clk);
  endtask

  // Compare both instances against the model for operation kind k
  task automatic expect_both(input string req, input int k);
    logic       legal64, legal32;
    legal64 = (k != 0) && en;
    legal32 = (k != 0) && en && (k < 4);
    chk({req, " res64"}, r64, legal64 ? ref64(k, a, b) : 64'h0);
    chk({req, " known64"}, {63'h0, k64}, {63'h0, k != 0});
    chk({req, " illegal64"}, {63'h0, x64}, {63'h0, (k != 0) && !legal64});
    chk({req, " res32"}, {32'h0, r32}, {32'h0, legal32 ? ref32(k, a[31:0], b[31:0]) : 32'h0});
    chk({req, " known32"}, {63'h0, k32}, {63'h0, k != 0});
    chk({req, " illegal32"}, {63'h0, x32}, {63'h0, (k != 0) && !legal32});
  endtask

  task automatic t_reset;
    chk("R10 reset res64", r64, 64'h0);
    chk("R10 reset flags", {62'h0, k64, x64}, 64'h0);
  endtask

  task automatic t_pack;
    apply(enc(7'b0000100, 3'b100, 7'b0110011, 5'd3, 5'd7, 5'd9),
          64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 1'b1);
    expect_both("R2 pack", 1);
    apply(enc(7'b0000100, 3'b100, 7'b0110011, 5'd31, 5'd0, 5'd17),
          64'hFFFF_FFFF_8000_0001, 64'h0000_0000_7FFF_FFFE, 1'b1);
    expect_both("R1 pack regfields", 1);
  endtask

  task automatic t_packu;
    apply(enc(7'b0100100, 3'b100, 7'b0110011, 5'd1, 5'd2, 5'd3),
          64'hDEAD_BEEF_0123_4567, 64'hCAFE_F00D_89AB_CDEF, 1'b1);
    expect_both("R3 packu", 2);
  endtask

  task automatic t_packh;
    apply(enc(7'b0000100, 3'b111, 7'b0110011, 5'd4, 5'd5, 5'd6),
          64'hFFFF_FFFF_FFFF_FFA5, 64'hFFFF_FFFF_FFFF_FF3C, 1'b1);
    expect_both("R4 packh", 3);
    chk("R4 packh upper zero", r64[63:16], 48'h0);
  endtask

  task automatic t_packw;
    apply(enc(7'b0000100, 3'b100, 7'b0111011, 5'd8, 5'd9, 5'd10),
          64'h5555_5555_AAAA_1234, 64'h6666_6666_BBBB_8765, 1'b1);
    expect_both("R5 packw neg", 4);
    chk("R5 packw value", r64, 64'hFFFF_FFFF_8765_1234);
    chk("R8 packw at 32", {62'h0, k32, x32}, 64'h3);
    apply(enc(7'b0000100, 3'b100, 7'b0111011, 5'd8, 5'd9, 5'd10),
          64'h0, 64'hFFFF_FFFF_FFFF_7FFF, 1'b1);
    expect_both("R5 packw pos", 4);
  endtask

  task automatic t_packuw;
    logic [63:0] first;
    apply(enc(7'b0100100, 3'b100, 7'b0111011, 5'd11, 5'd12, 5'd13),
          64'h0000_0000_4321_0000, 64'h0000_0000_F00F_0000, 1'b1);
    expect_both("R6 packuw", 5);
    first = r64;
    apply(enc(7'b0100100, 3'b100, 7'b0111011, 5'd11, 5'd12, 5'd13),
          64'hABCD_EF01_4321_FFFF, 64'h1234_5678_F00F_1111, 1'b1);
    chk("R6 packuw upper operand bits ignored", r64, first);
    chk("R8 packuw at 32 result zero", {32'h0, r32}, 64'h0);
  endtask

  task automatic t_disabled;
    apply(enc(7'b0000100, 3'b100, 7'b0110011, 5'd1, 5'd1, 5'd1),
          64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0);
    expect_both("R7 pack disabled", 1);
    apply(enc(7'b0100100, 3'b100, 7'b0111011, 5'd1, 5'd1, 5'd1),
          64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    expect_both("R7 packuw disabled", 5);
  endtask

  task automatic t_foreign;
    logic [63:0] x = 64'hFEDC_BA98_7654_3210;
    logic [63:0] y = 64'h0F1E_2D3C_4B5A_6978;
    apply(enc(7'b0000000, 3'b000, 7'b0110011, 5'd2, 5'd3, 5'd4), x, y, 1'b1);
    expect_both("R9 plain add", 0);
    apply(enc(7'b0100000, 3'b100, 7'b0110011, 5'd2, 5'd3, 5'd4), x, y, 1'b1);
    expect_both("R9 funct7 near miss", 0);
    apply(enc(7'b0100100, 3'b111, 7'b0110011, 5'd2, 5'd3, 5'd4), x, y, 1'b1);
    expect_both("R9 packu wrong funct3", 0);
    apply(enc(7'b0000100, 3'b111, 7'b0111011, 5'd2, 5'd3, 5'd4), x, y, 1'b1);
    expect_both("R9 byte form on word opcode", 0);
    apply(enc(7'b0000100, 3'b100, 7'b0010011, 5'd2, 5'd3, 5'd4), x, y, 1'b1);
    expect_both("R9 immediate opcode", 0);
  endtask

  task automatic t_latency;
    logic [63:0] prev;
    apply(enc(7'b0000100, 3'b111, 7'b0110011, 5'd0, 5'd0, 5'd0),
          64'h12, 64'h34, 1'b1);
    prev = r64;
    @(negedge clk);
    insn = enc(7'b0000100, 3'b100, 7'b0110011, 5'd0, 5'd0, 5'd0);
    a = 64'hAAAA_AAAA_0000_0001; b = 64'h0000_0000_0000_0002;
    #1;
    chk("R10 output held before edge", r64, prev);
    @(negedge clk);
    chk("R10 output after one edge", r64, 64'h0000_0002_0000_0001);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 sync reset res", r64, 64'h0);
    chk("R10 sync reset known", {63'h0, k64}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset release", r64, 64'h0000_0002_0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_pack();
    t_packu();
    t_packh();
    t_packw();
    t_packuw();
    t_disabled();
    t_foreign();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule